// File: doc/BRIEF.md
# Windowed Consensus Fitness Tracker

This block watches two copies of one function, a left half-configuration and a right half-configuration, that run side by side on live data. It needs no reference answer and no test vectors. On every valid sample it checks whether the two output words are bit-for-bit identical. Each copy that is in service counts the samples where the pair agreed and the samples where it did not. These counts run over a fixed evaluation window, 600 valid samples by default.

When a window closes, each copy's total discrepancy count is compared with integer limits. These limits stand in for the fitness ratio, which is agreements divided by window length. The result moves each copy through four health states: pristine, suspect, under repair and refurbished. A copy under repair is out of service and counts nothing. At every window close it is put back as refurbished when a pseudo-random draw hits a rate of about one in ten. It does not wait for its fitness to recover.

The per-copy states, the running counts, the window position and a repair-request vector are brought out. A higher-level controller uses them to launch and finish repairs.

Top module: `windowed_fitness_tracker`

## Requirements
- R1: After reset, both health states read pristine and all counts, the window position and the repair request are zero. States are encoded as pristine=0, suspect=1, under repair=2, refurbished=3.
- R2: A cycle with `smp_vld_i` low changes no output, whatever the data words carry.
- R3: A valid sample counts as agreement only when every bit of the left and right words matches; a single differing bit is a discrepancy. An in-service copy (state not 2) adds one to its hit count or its miss count on each valid sample, so hit plus miss equals `win_pos_o`.
- R4: `win_pos_o` counts valid samples from 0 to WIN_LEN-1. The valid sample taken at position WIN_LEN-1 closes the window: the position returns to 0 and the running counts of both copies clear.
- R5: At a window close, a pristine copy whose window total of misses (including the closing sample) exceeds SUSP_LIM (6) becomes suspect. Otherwise it stays pristine.
- R6: At a window close, a suspect copy with zero misses returns to pristine, one with more than REP_LIM (4) misses goes under repair, and otherwise it stays suspect.
- R7: A copy under repair keeps its hit and miss counts at zero. At each window close it becomes refurbished when its draw is below RATE_TH (6554). The left copy draws the generator value, and the right copy draws that value with its two bytes swapped.
- R8: The draw generator is a 16-bit shift register seeded with 0xACE1 at reset. It shifts left once per window close, taking in bit15^bit13^bit12^bit10. The draw at a close uses the value held before that shift.
- R9: At a window close, a refurbished copy with zero misses becomes pristine, one with more than REP_LIM misses goes back under repair, and otherwise it stays refurbished.
- R10: `repair_req_o[0]` is high exactly while the left state is 2, and `repair_req_o[1]` is high exactly while the right state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe |
| left_word_i | input | DW | Output word of the left copy |
| right_word_i | input | DW | Output word of the right copy |
| win_pos_o | output | CW | Valid samples taken in the current window |
| left_state_o | output | 2 | Health state of the left copy |
| right_state_o | output | 2 | Health state of the right copy |
| left_miss_o | output | CW | Left running discrepancy count |
| left_hit_o | output | CW | Left running agreement count |
| right_miss_o | output | CW | Right running discrepancy count |
| right_hit_o | output | CW | Right running agreement count |
| repair_req_o | output | 2 | Repair request, bit 0 left, bit 1 right |

## Verification
A wrong count shows up on the very next cycle, because the hit and miss sum drifts away from the window position. A misjudged comparison shows as a count moving the wrong way on the cycle after the sample. A wrong threshold, wrong transition or wrong draw stays hidden until the window closes. It then shows on the state outputs one cycle after the closing sample, so window totals are driven right at the limits, at 6 and 7 misses and at 4 and 5 misses. A slip in the generator or in the byte swap shows at the first window close where a copy under repair is reintroduced too early or too late. The two copies then drift apart in state from that point on.

// File: rtl/fitness_pkg.sv
package fitness_pkg;
  typedef enum logic [1:0] {
    HS_PRISTINE = 2'd0,
    HS_SUSPECT  = 2'd1,
    HS_REPAIR   = 2'd2,
    HS_REFURB   = 2'd3
  } health_e;

  localparam int NCFG = 2;

  function automatic logic [15:0] rng_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction
endpackage

// File: rtl/word_agree.sv
module word_agree #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          same_o
);
  always_comb same_o = &(a_i ~^ b_i);
endmodule

// File: rtl/window_pos.sv
module window_pos #(
  parameter int WIN_LEN = 600,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  output logic [CW-1:0] pos_o,
  output logic          close_o
);
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  always_comb close_o = vld_i && (pos_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) pos_o <= '0;
    else if (vld_i) pos_o <= close_o ? '0 : pos_o + CW'(1);
  end
endmodule

// File: rtl/reintro_draw.sv
module reintro_draw #(
  parameter int          RATE_TH = 6554,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step_i,
  output logic [fitness_pkg::NCFG-1:0] hit_o
);
  import fitness_pkg::*;
  localparam logic [15:0] TH16 = 16'(RATE_TH);

  logic [15:0] rng_q;

  always_comb begin
    hit_o[0] = rng_q < TH16;
    hit_o[1] = {rng_q[7:0], rng_q[15:8]} < TH16;
  end

  always_ff @(posedge clk) begin
    if (rst) rng_q <= SEED;
    else if (step_i) rng_q <= rng_step(rng_q);
  end
endmodule

// File: rtl/cfg_health.sv
module cfg_health #(
  parameter int CW       = 10,
  parameter int SUSP_LIM = 6,
  parameter int REP_LIM  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic                 same_i,
  input  logic                 close_i,
  input  logic                 draw_hit_i,
  output fitness_pkg::health_e state_o,
  output logic [CW-1:0]        miss_o,
  output logic [CW-1:0]        hit_o,
  output logic                 req_o
);
  import fitness_pkg::*;
  localparam logic [CW-1:0] SUSP_C = CW'(SUSP_LIM);
  localparam logic [CW-1:0] REP_C  = CW'(REP_LIM);

  logic          in_svc;
  logic [CW-1:0] miss_tot;
  health_e       nxt;

  always_comb begin
    in_svc   = (state_o != HS_REPAIR);
    miss_tot = miss_o + CW'(in_svc && !same_i);
    nxt      = state_o;
    unique case (state_o)
      HS_PRISTINE: if (miss_tot > SUSP_C) nxt = HS_SUSPECT;
      HS_SUSPECT: begin
        if (miss_tot > REP_C) nxt = HS_REPAIR;
        else if (miss_tot == '0) nxt = HS_PRISTINE;
      end
      HS_REPAIR: if (draw_hit_i) nxt = HS_REFURB;
      HS_REFURB: begin
        if (miss_tot > REP_C) nxt = HS_REPAIR;
        else if (miss_tot == '0) nxt = HS_PRISTINE;
      end
      default: nxt = HS_PRISTINE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= HS_PRISTINE;
      miss_o  <= '0;
      hit_o   <= '0;
      req_o   <= 1'b0;
    end else if (vld_i) begin
      if (close_i) begin
        state_o <= nxt;
        req_o   <= (nxt == HS_REPAIR);
        miss_o  <= '0;
        hit_o   <= '0;
      end else if (in_svc) begin
        if (same_i) hit_o  <= hit_o + CW'(1);
        else        miss_o <= miss_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/windowed_fitness_tracker.sv
module windowed_fitness_tracker #(
  parameter int          DW       = 16,
  parameter int          WIN_LEN  = 600,
  parameter int          SUSP_LIM = 6,
  parameter int          REP_LIM  = 4,
  parameter int          RATE_TH  = 6554,
  parameter logic [15:0] SEED     = 16'hACE1,
  parameter int          CW       = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] left_word_i,
  input  logic [DW-1:0] right_word_i,
  output logic [CW-1:0] win_pos_o,
  output logic [1:0]    left_state_o,
  output logic [1:0]    right_state_o,
  output logic [CW-1:0] left_miss_o,
  output logic [CW-1:0] left_hit_o,
  output logic [CW-1:0] right_miss_o,
  output logic [CW-1:0] right_hit_o,
  output logic [1:0]    repair_req_o
);
  import fitness_pkg::*;

  logic                same;
  logic                close;
  logic [NCFG-1:0]     draw_hit;
  health_e             st   [NCFG];
  logic [CW-1:0]       miss [NCFG];
  logic [CW-1:0]       hits [NCFG];

  word_agree #(.DW(DW)) u_agree (
    .a_i(left_word_i), .b_i(right_word_i), .same_o(same)
  );

  window_pos #(.WIN_LEN(WIN_LEN), .CW(CW)) u_pos (
    .clk(clk), .rst(rst), .vld_i(smp_vld_i), .pos_o(win_pos_o), .close_o(close)
  );

  reintro_draw #(.RATE_TH(RATE_TH), .SEED(SEED)) u_draw (
    .clk(clk), .rst(rst), .step_i(close), .hit_o(draw_hit)
  );

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    cfg_health #(.CW(CW), .SUSP_LIM(SUSP_LIM), .REP_LIM(REP_LIM)) u_hl (
      .clk(clk), .rst(rst), .vld_i(smp_vld_i), .same_i(same),
      .close_i(close), .draw_hit_i(draw_hit[c]),
      .state_o(st[c]), .miss_o(miss[c]), .hit_o(hits[c]),
      .req_o(repair_req_o[c])
    );
  end

  always_comb begin
    left_state_o  = st[0];
    right_state_o = st[1];
    left_miss_o   = miss[0];
    left_hit_o    = hits[0];
    right_miss_o  = miss[1];
    right_hit_o   = hits[1];
  end
endmodule

// File: rtl/fitness_tracker_chk.sv
module fitness_tracker_chk #(
  parameter int WIN_LEN = 600,
  parameter int CW      = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_vld_i,
  input logic [CW-1:0] win_pos_o,
  input logic [1:0]    left_state_o,
  input logic [1:0]    right_state_o,
  input logic [CW-1:0] left_miss_o,
  input logic [CW-1:0] left_hit_o,
  input logic [CW-1:0] right_miss_o,
  input logic [CW-1:0] right_hit_o,
  input logic [1:0]    repair_req_o
);
  // R4
  pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    win_pos_o < CW'(WIN_LEN));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld_i |=> $stable(win_pos_o) && $stable(left_state_o) && $stable(right_state_o));

  // R3
  left_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (left_state_o != 2'd2) |-> (left_miss_o + left_hit_o == win_pos_o));

  // R3
  right_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (right_state_o != 2'd2) |-> (right_miss_o + right_hit_o == win_pos_o));

  // R7
  repair_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (left_state_o == 2'd2) |-> (left_miss_o == '0 && left_hit_o == '0));

  // R7
  repair_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(right_state_o) == 2'd2) |-> right_state_o[1]);

  // R5
  state_at_close_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(left_state_o) |-> (win_pos_o == '0));

  // R10
  req_match_chk: assert property (@(posedge clk) disable iff (rst)
    (repair_req_o[0] == (left_state_o == 2'd2)) && (repair_req_o[1] == (right_state_o == 2'd2)));
endmodule

bind windowed_fitness_tracker fitness_tracker_chk #(.WIN_LEN(WIN_LEN), .CW(CW)) u_chk (.*);

// File: tb/tb_windowed_fitness_tracker.sv
module tb_windowed_fitness_tracker;
  localparam int DW  = 16;
  localparam int WIN = 600;
  localparam int CW  = $clog2(WIN + 1);
  localparam int NW  = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld_i = 1'b0;
  logic [DW-1:0] left_word_i = '0, right_word_i = '0;
  logic [CW-1:0] win_pos_o, left_miss_o, left_hit_o, right_miss_o, right_hit_o;
  logic [1:0] left_state_o, right_state_o, repair_req_o;

  always #5 clk = ~clk;

  windowed_fitness_tracker dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  int m_state[2], m_miss[2], m_hit[2], m_pos;
  logic [15:0] m_rng;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag_cnt);
    chk("R5 R6 R7 R8 R9", "left state", int'(left_state_o), m_state[0]);
    chk("R5 R6 R7 R8 R9", "right state", int'(right_state_o), m_state[1]);
    chk(tag_cnt, "left miss", int'(left_miss_o), m_miss[0]);
    chk(tag_cnt, "left hit", int'(left_hit_o), m_hit[0]);
    chk(tag_cnt, "right miss", int'(right_miss_o), m_miss[1]);
    chk(tag_cnt, "right hit", int'(right_hit_o), m_hit[1]);
    chk("R4", "window position", int'(win_pos_o), m_pos);
    chk("R10", "repair request", int'(repair_req_o),
        ((m_state[1] == 2) ? 2 : 0) + ((m_state[0] == 2) ? 1 : 0));
  endtask

  function automatic int next_state(int s, int tot, bit draw);
    case (s)
      0: return (tot > 6) ? 1 : 0;                          // R5
      1: return (tot > 4) ? 2 : ((tot == 0) ? 0 : 1);       // R6
      2: return draw ? 3 : 2;                               // R7
      default: return (tot > 4) ? 2 : ((tot == 0) ? 0 : 3); // R9
    endcase
  endfunction

  task automatic model_step(bit vld, bit same);
    bit last;
    if (!vld) return;
    last = (m_pos == WIN - 1);
    for (int c = 0; c < 2; c++) begin
      bit insvc = (m_state[c] != 2);
      int tot = m_miss[c] + ((insvc && !same) ? 1 : 0);
      if (last) begin
        logic [15:0] d = (c == 0) ? m_rng : {m_rng[7:0], m_rng[15:8]};
        m_state[c] = next_state(m_state[c], tot, d < 16'd6554);
        m_miss[c] = 0;
        m_hit[c] = 0;
      end else if (insvc) begin
        if (same) m_hit[c]++;
        else m_miss[c]++;
      end
    end
    if (last) begin
      m_pos = 0;
      m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]}; // R8
    end else m_pos++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int dir[7] = '{0, 6, 7, 4, 0, 7, 5};
    int pool[6] = '{0, 0, 3, 5, 7, 9};
    string tag;
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      m_state[c] = 0; m_miss[c] = 0; m_hit[c] = 0;
    end
    m_pos = 0;
    m_rng = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all("R1");
    for (int w = 0; w < NW; w++) begin
      int m = (w < 7) ? dir[w] : pool[$urandom % 6];
      int off = $urandom % WIN;
      int smp = 0;
      bit vld = 1'b1;
      while (smp < WIN) begin
        bit mis;
        logic [DW-1:0] a;
        if (smp > 0 || w > 0) begin
          @(negedge clk);
          tag = vld ? "R3" : "R2";
          compare_all(tag);
        end
        vld = ($urandom % 4) != 0;
        a = DW'($urandom);
        if (vld) begin
          mis = ((smp * 37 + off) % WIN) < m;
          left_word_i  = a;
          right_word_i = mis ? (a ^ (DW'(1) << ($urandom % DW))) : a;
          smp++;
        end else begin
          left_word_i  = a;
          right_word_i = ~a;
        end
        smp_vld_i = vld;
        model_step(vld, left_word_i == right_word_i);
      end
    end
    @(negedge clk);
    compare_all("R3");
    smp_vld_i = 1'b0;
    @(negedge clk);
    compare_all("R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule